// File: doc/BRIEF.md
# Cycle/Scanline Interrupt Timer

This block raises an interrupt after a programmable number of counter ticks. An 8-bit counter counts upward from a reload value. When it passes from all ones back to zero, it takes the reload value again and asserts the interrupt line. Ticks come from one of two sources. In cycle mode the counter ticks on every enabled clock. In scanline mode a signed prescaler emulates one video line: it removes three from its value on each enabled clock and adds the line period of 341 when the result reaches zero or below. This gives ticks on a 114, 114, 113 clock cadence, which is 341 clocks for every three ticks.

Software uses three write strobes that share one data byte. The reload strobe stores the reload value. The control strobe sets the mode and the enable, and restarts the counter. The acknowledge strobe clears the interrupt and can re-arm the timer from a stored bit. A clock enable qualifies the clock for counting, but it does not gate register writes. The write strobes and the interrupt are plain control pins and have no handshake.

Top module: `scan_irq_timer`

## Requirements
- R1: Synchronous reset deasserts `irq`, clears mode, enable and re-arm, sets the reload value and the counter to 0, and sets the prescaler to 341.
- R2: A `wr_latch` write stores `wr_data` as the reload value. It does not change the counter that is already running; the new value is used at the next wrap.
- R3: A `wr_ctrl` write takes bit 2 as the mode (1 = cycle, 0 = scanline), bit 1 as the enable and bit 0 as the re-arm bit. When bit 1 is set, the write loads the counter from the reload value and sets the prescaler to 341. Every control write clears `irq`, and no tick happens in the cycle of the write.
- R4: In cycle mode with enable set, the counter ticks on each clock where `clk_en` is high. With reload value L, `irq` rises 256-L clocks after the control write.
- R5: In scanline mode with enable set, each enabled clock subtracts 3 from the prescaler. A result of 0 or less adds 341 and makes one tick. The first tick comes 114 clocks after a control write, and the ticks follow at 114, 114, 113.
- R6: Each tick increments the counter. A tick at 0xFF reloads the counter from the reload value and sets `irq`.
- R7: Once set, `irq` stays high until a control or acknowledge write.
- R8: A `wr_ack` write clears `irq` and copies the re-arm bit into the enable. With the re-arm bit at 0, no further interrupt occurs.
- R9: If a wrap and an acknowledge fall in the same clock, `irq` stays set.
- R10: While `clk_en` is low, the counter and the prescaler hold their values, and register writes still take effect.
- R11: With enable clear, no ticks occur and `irq` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Counting qualifier |
| wr_latch | input | 1 | Reload value write strobe |
| wr_ctrl | input | 1 | Control write strobe |
| wr_ack | input | 1 | Acknowledge write strobe |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong count or a wrong prescaler value shows only as a shift in when `irq` rises. The bench therefore measures the distance in clocks from the control or acknowledge write to the interrupt edge, and compares it with the exact count. An off-by-one in the scanline cadence appears as 113 or 115 in place of 114, and it builds up to a visible error over three ticks (341 clocks). Sticky and cleared interrupt states appear on `irq` within one clock of the write that should change them.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef enum logic {
    MODE_SCANLINE = 1'b0,
    MODE_CYCLE    = 1'b1
  } tick_mode_e;

  localparam int CTRL_MODE_BIT  = 2;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_REARM_BIT = 0;
endpackage

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic tick
);
  localparam int PW = $clog2(PERIOD) + 2;
  localparam logic signed [PW-1:0] PERIOD_V = PW'(PERIOD);
  localparam logic signed [PW-1:0] STEP_V   = PW'(STEP);

  logic signed [PW-1:0] acc;
  logic signed [PW-1:0] diff;
  logic                 nonpos;

  always_comb begin
    diff   = acc - STEP_V;
    nonpos = diff[PW-1] | (diff == '0);
    tick   = run & nonpos;
  end

  always_ff @(posedge clk) begin
    if (rst || load) acc <= PERIOD_V;
    else if (run) acc <= nonpos ? diff + PERIOD_V : diff;
  end

  assert_presc_range_R5: assert property (@(posedge clk) disable iff (rst)
    (acc > 0) && (acc <= PERIOD_V));
  assert_tick_refill_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (acc > PERIOD_V - STEP_V - STEP_V + 1) || (acc > PERIOD_V - STEP_V));
endmodule

// File: rtl/irqt_counter.sv
module irqt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_we,
  input  logic          load,
  input  logic          tick,
  input  logic          irq_clr,
  input  logic [CW-1:0] data,
  output logic [CW-1:0] count,
  output logic          irq
);
  logic [CW-1:0] reload;
  logic          wrap;

  assign wrap = tick & (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
      count  <= '0;
      irq    <= 1'b0;
    end else begin
      if (latch_we) reload <= data;
      if (load) count <= reload;
      else if (wrap) count <= reload;
      else if (tick) count <= count + 1'b1;
      if (wrap) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> irq);
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  assert_clear_wins_not_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !wrap) |=> !irq);
endmodule

// File: rtl/irqt_ctrl.sv
module irqt_ctrl
  import irqt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic       ack_we,
  input  logic [7:0] data,
  output tick_mode_e mode,
  output logic       enable
);
  logic rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_SCANLINE;
      enable <= 1'b0;
      rearm  <= 1'b0;
    end else if (ctrl_we) begin
      mode   <= tick_mode_e'(data[CTRL_MODE_BIT]);
      enable <= data[CTRL_EN_BIT];
      rearm  <= data[CTRL_REARM_BIT];
    end else if (ack_we) begin
      enable <= rearm;
    end
  end

  assert_ack_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_we && !ctrl_we) |=> (enable == $past(rearm)));
endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer
  import irqt_pkg::*;
#(
  parameter int CW     = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          wr_latch,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [CW-1:0] wr_data,
  output logic          irq
);
  tick_mode_e    mode;
  logic          enable;
  logic          load;
  logic          live;
  logic          presc_tick;
  logic          tick;
  logic [CW-1:0] count;

  irqt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(wr_ctrl), .ack_we(wr_ack),
    .data(8'(wr_data)), .mode(mode), .enable(enable)
  );

  assign load = wr_ctrl & wr_data[CTRL_EN_BIT];
  assign live = clk_en & enable & ~wr_ctrl;

  irqt_prescaler #(.PERIOD(PERIOD), .STEP(STEP)) u_presc (
    .clk(clk), .rst(rst), .load(load),
    .run(live & (mode == MODE_SCANLINE)), .tick(presc_tick)
  );

  assign tick = (live & (mode == MODE_CYCLE)) | presc_tick;

  irqt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .latch_we(wr_latch), .load(load), .tick(tick),
    .irq_clr(wr_ctrl | wr_ack), .data(wr_data), .count(count), .irq(irq)
  );

  assert_ctrl_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> !irq);
  assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !wr_ctrl) |=> $stable(count));
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_ctrl) |=> $stable(count));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && count == '0));
endmodule

// File: tb/scan_irq_timer_test.sv
module scan_irq_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b1;
  logic       wr_latch = 1'b0, wr_ctrl = 1'b0, wr_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq;
  int checks = 0, errors = 0, cycles = 0;

  scan_irq_timer uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .wr_latch(wr_latch),
    .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wr_data(wr_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {reload value, control byte, clocks until irq}
  localparam logic [27:0] VEC [8] = '{
    {8'hFF, 8'h06, 12'd1},   {8'hF0, 8'h06, 12'd16},
    {8'h00, 8'h06, 12'd256}, {8'h80, 8'h07, 12'd128},
    {8'hFF, 8'h02, 12'd114}, {8'hFE, 8'h02, 12'd228},
    {8'hFD, 8'h02, 12'd341}, {8'hFC, 8'h03, 12'd455}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    wr_data  = d;
    wr_latch = (sel == 0);
    wr_ctrl  = (sel == 1);
    wr_ack   = (sel == 2);
    @(posedge clk); @(negedge clk);
    wr_latch = 0; wr_ctrl = 0; wr_ack = 0;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    while (n < max) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (irq) break;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    @(negedge clk); idle(2);
    rst = 0;
    check("R1 irq after reset", irq, 0);

    foreach (VEC[i]) begin
      wr(0, VEC[i][27:20]);
      wr(1, VEC[i][19:12]);
      wait_irq(600, n);
      check("R4/R5/R6 clocks to irq", n, int'(VEC[i][11:0]));
      wr(1, 8'h00);
      check("R3 control write clears irq", irq, 0);
    end

    // R7: sticky
    wr(0, 8'hF0); wr(1, 8'h06); wait_irq(40, n);
    idle(5);
    check("R7 irq held", irq, 1);
    // R8: ack with rearm 0 stops the timer
    wr(2, 8'h00);
    check("R8 ack clears irq", irq, 0);
    idle(300);
    check("R8 disabled after ack", irq, 0);

    // R8: ack with rearm 1 keeps counting
    wr(1, 8'h07); wait_irq(40, n);
    check("R8 first irq", n, 16);
    wr(2, 8'h00);
    check("R8 ack clears", irq, 0);
    wait_irq(40, n);
    check("R8 rearmed interval", n, 15);

    // R9: wrap and ack in same clock
    wr(0, 8'hFF); wr(1, 8'h07); wait_irq(10, n);
    wr(2, 8'h00);
    check("R9 set wins over ack", irq, 1);
    wr(1, 8'h04);
    idle(300);
    check("R11 disabled no irq", irq, 0);

    // R2: reload write mid-run
    wr(0, 8'hF0); wr(1, 8'h07); idle(4);
    wr(0, 8'h00);
    wait_irq(40, n);
    check("R2 running count kept", n, 11);
    wr(2, 8'h00);
    wait_irq(400, n);
    check("R2 new reload used", n, 255);

    // R10: clk_en low
    wr(1, 8'h00);
    clk_en = 0;
    wr(0, 8'hFE); wr(1, 8'h06);
    idle(10);
    check("R10 frozen", irq, 0);
    clk_en = 1;
    wait_irq(10, n);
    check("R10 resumes", n, 2);

    // R5: control write restarts prescaler
    wr(0, 8'hFF); wr(1, 8'h02);
    wait_irq(50, n);
    check("R5 no tick before 114", irq, 0);
    wr(1, 8'h02);
    wait_irq(200, n);
    check("R5 prescaler reloaded", n, 114);

    // R1: reset clears reload value
    rst = 1; idle(1); rst = 0;
    check("R1 irq cleared by reset", irq, 0);
    wr(1, 8'h06);
    wait_irq(400, n);
    check("R1 reload value zero", n, 256);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule